// File: doc/BRIEF.md
# Dual-Agent Mailbox Slot Pool

This block tracks the message slots of a shared-memory region that carries messages in both directions between a host CPU (agent 0) and an embedded engine (agent 1). It never touches the message bytes. It holds only slot indices and turns them into byte addresses. An initialization pulse loads the region base, the slot size (32 or 64 bytes) and the number of slots. It also puts every slot back into the pool and empties both mailboxes.

A sender requests a free slot and receives that slot's address and index one cycle later, with a valid bit. It fills the slot in memory outside this block, then posts the index. The posted index goes into the other agent's mailbox. The recipient reads its mailbox to get the oldest pending slot. Once it has finished with the message, it releases the index back to the pool. Each agent has a level interrupt that is high while its mailbox holds mail.

Top module: `mbx_pool`

## Requirements
- R1: After reset, and after an `init_i` pulse, every configured slot is free, both mailboxes are empty and both `irq_o` bits are low. Mail pending before `init_i` is discarded.
- R2: A returned address equals the base plus the slot index shifted left by 6 when `cfg_wide_i` was 1 at init (64-byte slots), or by 5 when it was 0 (32-byte slots). After reset the base is 0 and the slots are 32 bytes.
- R3: Slot indices start at 0. After reset or init, successive allocations return 0, 1, 2, … in ascending order.
- R4: An allocation request pulse on `alloc_req_i[a]` yields a one-cycle `alloc_vld_o[a]` on the next cycle. When the pool is empty, `alloc_ok_o[a]` is 0 and the pool is left unchanged.
- R5: Released slots are handed out again in the order they were released, after the never-used slots.
- R6: Writing an index on `post_we_i[a]` appends it to the mailbox of agent 1-a. A read pulse on `mbx_rd_i[a]` returns the oldest pending index (FIFO order) on the next cycle, with `mbx_ok_o[a]`=1, and removes it from the mailbox.
- R7: Reading an empty mailbox returns `mbx_ok_o[a]`=0 and changes nothing.
- R8: `irq_o[a]` is high exactly while mailbox a holds at least one pending slot. It rises only after a post by the other agent.
- R9: When both agents request in the same cycle and no request is pending, the CPU is answered on the next cycle and the engine on the cycle after that. The two agents get distinct slots. At most one allocation is answered per cycle.
- R10: Both agents may release in the same cycle. Both slots are accepted, with the CPU's slot ahead of the engine's in the free order.
- R11: Exactly as many allocations succeed as the slot count given at init (128 to 1024).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Load configuration and empty pool and mailboxes |
| cfg_base_i | input | AW | Byte base of the slot region |
| cfg_wide_i | input | 1 | 1: 64-byte slots, 0: 32-byte slots |
| cfg_count_i | input | IDXW+1 | Number of slots |
| alloc_req_i | input | 2 | Free-slot read request per agent (bit 0 CPU) |
| alloc_vld_o | output | 2 | Free-slot response strobe per agent |
| alloc_ok_o | output | 2 | Response valid bit: a slot was granted |
| alloc_idx_o | output | 2 x IDXW | Granted slot index per agent |
| alloc_addr_o | output | 2 x AW | Granted slot address per agent |
| post_we_i | input | 2 | Post a slot to the other agent |
| post_idx_i | input | 2 x IDXW | Posted slot index per agent |
| rel_we_i | input | 2 | Release a slot to the pool |
| rel_idx_i | input | 2 x IDXW | Released slot index per agent |
| mbx_rd_i | input | 2 | Mailbox read request per agent |
| mbx_vld_o | output | 2 | Mailbox response strobe |
| mbx_ok_o | output | 2 | Mailbox response valid bit |
| mbx_idx_o | output | 2 x IDXW | Pending slot index |
| mbx_addr_o | output | 2 x AW | Pending slot address |
| irq_o | output | 2 | Level interrupt: mailbox not empty |

## Verification
The two agents can ask for a free slot in the same cycle, and they can also release slots in the same cycle. The bench provokes the first by raising both request bits on one edge. It checks that only the CPU's strobe appears on the first response cycle and that the engine's strobe appears alone on the next, each with its own ascending slot. For the second, it drains the pool, releases two indices on one edge, and checks that they come back in CPU-then-engine order, followed by a failed allocation.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic {
    AG_CPU = 1'b0,
    AG_ENG = 1'b1
  } agent_e;

  localparam int unsigned NAGENT = 2;
  localparam int unsigned SHIFT_NARROW = 5;
  localparam int unsigned SHIFT_WIDE   = 6;
endpackage

// File: rtl/mbx_ring.sv
module mbx_ring #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned W     = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_a_i,
  input  logic [W-1:0] din_a_i,
  input  logic         push_b_i,
  input  logic [W-1:0] din_b_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = PW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (clr_i) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      wp_d  = wp_q + PW'(push_a_i) + PW'(push_b_i);
      rp_d  = rp_q + PW'(pop_i);
      cnt_d = cnt_q + CW'(push_a_i) + CW'(push_b_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  // storage: no reset, written only on accepted pushes
  always_ff @(posedge clk_i) begin
    if (push_a_i) mem[wp_q] <= din_a_i;
    if (push_b_i) mem[wp_q + PW'(push_a_i)] <= din_b_i;
  end

  assign head_o  = mem[rp_q];
  assign empty_o = (cnt_q == '0);

  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |-> (({1'b0, cnt_q} + (CW+1)'(push_a_i) + (CW+1)'(push_b_i)
                 - (CW+1)'(pop_i)) <= (CW+1)'(DEPTH)))
    else $error("ring overflow");

  p_no_underflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o)
    else $error("ring underflow");
endmodule

// File: rtl/mbx_alloc_arb.sv
module mbx_alloc_arb (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic [1:0] req_i,
  output logic [1:0] gnt_o,
  output logic [1:0] pend_o
);
  logic [1:0] pend_q, pend_d, want;

  always_comb begin
    want     = req_i | pend_q;
    // a deferred engine request outranks a new CPU request
    gnt_o[1] = pend_q[1] | (want[1] & ~want[0]);
    gnt_o[0] = want[0] & ~pend_q[1];
    pend_d   = clr_i ? 2'b00 : (want & ~gnt_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 2'b00;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  p_one_grant_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o))
    else $error("two grants in one cycle");

  p_defer_served_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == 2'b11 && pend_q == 2'b00 && !clr_i) |=> gnt_o[1])
    else $error("deferred engine request not served next cycle");
endmodule

// File: rtl/mbx_pool.sv
module mbx_pool #(
  parameter int unsigned AW        = 32,
  parameter int unsigned IDXW      = 10,
  parameter int unsigned RST_COUNT = 128,
  parameter int unsigned RST_BASE  = 0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      init_i,
  input  logic [AW-1:0]             cfg_base_i,
  input  logic                      cfg_wide_i,
  input  logic [IDXW:0]             cfg_count_i,
  input  logic [1:0]                alloc_req_i,
  output logic [1:0]                alloc_vld_o,
  output logic [1:0]                alloc_ok_o,
  output logic [1:0][IDXW-1:0]      alloc_idx_o,
  output logic [1:0][AW-1:0]        alloc_addr_o,
  input  logic [1:0]                post_we_i,
  input  logic [1:0][IDXW-1:0]      post_idx_i,
  input  logic [1:0]                rel_we_i,
  input  logic [1:0][IDXW-1:0]      rel_idx_i,
  input  logic [1:0]                mbx_rd_i,
  output logic [1:0]                mbx_vld_o,
  output logic [1:0]                mbx_ok_o,
  output logic [1:0][IDXW-1:0]      mbx_idx_o,
  output logic [1:0][AW-1:0]        mbx_addr_o,
  output logic [1:0]                irq_o
);
  import mbx_pkg::*;

  localparam int unsigned DEPTH = 1 << IDXW;
  localparam int unsigned CW    = IDXW + 1;

  // configuration and lazy-fill counter
  logic [AW-1:0] base_q, base_d;
  logic          wide_q, wide_d;
  logic [CW-1:0] lim_q, lim_d, fresh_q, fresh_d;
  logic [2:0]    shamt;

  // allocation path
  logic [1:0]      req_gated, gnt, pend;
  logic            fresh_avail, free_empty, free_pop, take_ok;
  logic [IDXW-1:0] free_head, take_idx;
  logic [1:0]      rel_push;

  logic [1:0]            avld_q, avld_d, aok_q, aok_d;
  logic [1:0][IDXW-1:0]  aidx_q, aidx_d;

  // mailbox path
  logic [1:0]            box_empty, box_pop, box_push;
  logic [1:0][IDXW-1:0]  box_head;
  logic [1:0]            mvld_q, mvld_d, mok_q, mok_d;
  logic [1:0][IDXW-1:0]  midx_q, midx_d;

  assign req_gated = alloc_req_i & {2{~init_i}};
  assign rel_push  = rel_we_i & {2{~init_i}};
  assign shamt     = wide_q ? 3'(SHIFT_WIDE) : 3'(SHIFT_NARROW);

  mbx_alloc_arb u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (init_i),
    .req_i  (req_gated),
    .gnt_o  (gnt),
    .pend_o (pend)
  );

  // never-used slots come from the counter first, then recycled ones
  assign fresh_avail = (fresh_q < lim_q);
  assign take_ok     = fresh_avail | ~free_empty;
  assign take_idx    = fresh_avail ? fresh_q[IDXW-1:0] : free_head;
  assign free_pop    = (|gnt) & ~fresh_avail & ~free_empty;

  mbx_ring #(.DEPTH(DEPTH), .W(IDXW)) u_free (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (init_i),
    .push_a_i (rel_push[AG_CPU]),
    .din_a_i  (rel_idx_i[AG_CPU]),
    .push_b_i (rel_push[AG_ENG]),
    .din_b_i  (rel_idx_i[AG_ENG]),
    .pop_i    (free_pop),
    .head_o   (free_head),
    .empty_o  (free_empty)
  );

  always_comb begin
    base_d  = base_q;
    wide_d  = wide_q;
    lim_d   = lim_q;
    fresh_d = fresh_q;
    if (init_i) begin
      base_d  = cfg_base_i;
      wide_d  = cfg_wide_i;
      lim_d   = cfg_count_i;
      fresh_d = '0;
    end else if ((|gnt) && fresh_avail) begin
      fresh_d = fresh_q + CW'(1);
    end
  end

  always_comb begin
    avld_d = gnt;
    aok_d  = aok_q;
    aidx_d = aidx_q;
    for (int a = 0; a < NAGENT; a++) begin
      if (gnt[a]) begin
        aok_d[a]  = take_ok;
        aidx_d[a] = take_ok ? take_idx : '0;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NAGENT; g++) begin : g_box
      // a post from the other agent lands in this agent's mailbox
      assign box_push[g] = post_we_i[1-g] & ~init_i;
      assign box_pop[g]  = mbx_rd_i[g] & ~init_i & ~box_empty[g];

      mbx_ring #(.DEPTH(DEPTH), .W(IDXW)) u_box (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (init_i),
        .push_a_i (box_push[g]),
        .din_a_i  (post_idx_i[1-g]),
        .push_b_i (1'b0),
        .din_b_i  ({IDXW{1'b0}}),
        .pop_i    (box_pop[g]),
        .head_o   (box_head[g]),
        .empty_o  (box_empty[g])
      );

      assign mvld_d[g] = mbx_rd_i[g] & ~init_i;
      assign mok_d[g]  = mvld_d[g] ? ~box_empty[g] : mok_q[g];
      assign midx_d[g] = mvld_d[g] ? (box_empty[g] ? '0 : box_head[g]) : midx_q[g];

      assign irq_o[g]        = ~box_empty[g];
      assign alloc_addr_o[g] = base_q + (AW'(aidx_q[g]) << shamt);
      assign mbx_addr_o[g]   = base_q + (AW'(midx_q[g]) << shamt);

      p_irq_after_post_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o[g]) |-> $past(post_we_i[1-g]))
        else $error("interrupt rose without a post");
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= AW'(RST_BASE);
      wide_q  <= 1'b0;
      lim_q   <= CW'(RST_COUNT);
      fresh_q <= '0;
      avld_q  <= '0;
      aok_q   <= '0;
      aidx_q  <= '0;
      mvld_q  <= '0;
      mok_q   <= '0;
      midx_q  <= '0;
    end else begin
      base_q  <= base_d;
      wide_q  <= wide_d;
      lim_q   <= lim_d;
      fresh_q <= fresh_d;
      avld_q  <= avld_d;
      aok_q   <= aok_d;
      aidx_q  <= aidx_d;
      mvld_q  <= mvld_d;
      mok_q   <= mok_d;
      midx_q  <= midx_d;
    end
  end

  assign alloc_vld_o = avld_q;
  assign alloc_ok_o  = aok_q;
  assign alloc_idx_o = aidx_q;
  assign mbx_vld_o   = mvld_q;
  assign mbx_ok_o    = mok_q;
  assign mbx_idx_o   = midx_q;

  p_cpu_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_req_i == 2'b11 && pend == 2'b00 && !init_i) |=> (alloc_vld_o == 2'b01))
    else $error("CPU not answered first");

  p_single_answer_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(alloc_vld_o))
    else $error("two allocation answers in one cycle");
endmodule

// File: tb/mbx_pool_bench.sv
`timescale 1ns/1ps
module mbx_pool_bench;
  localparam int AW = 32;
  localparam int IW = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic init;
  logic [AW-1:0] cfg_base;
  logic cfg_wide;
  logic [IW:0] cfg_count;
  logic [1:0] alloc_req, alloc_vld, alloc_ok;
  logic [1:0][IW-1:0] alloc_idx, post_idx, rel_idx, mbx_idx;
  logic [1:0][AW-1:0] alloc_addr, mbx_addr;
  logic [1:0] post_we, rel_we, mbx_rd, mbx_vld, mbx_ok, irq;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mbx_pool #(.AW(AW), .IDXW(IW)) u_mbx_pool (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init),
    .cfg_base_i(cfg_base), .cfg_wide_i(cfg_wide), .cfg_count_i(cfg_count),
    .alloc_req_i(alloc_req), .alloc_vld_o(alloc_vld), .alloc_ok_o(alloc_ok),
    .alloc_idx_o(alloc_idx), .alloc_addr_o(alloc_addr),
    .post_we_i(post_we), .post_idx_i(post_idx),
    .rel_we_i(rel_we), .rel_idx_i(rel_idx),
    .mbx_rd_i(mbx_rd), .mbx_vld_o(mbx_vld), .mbx_ok_o(mbx_ok),
    .mbx_idx_o(mbx_idx), .mbx_addr_o(mbx_addr), .irq_o(irq)
  );

  task automatic chk(input bit good, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_init(input logic [AW-1:0] b, input logic w, input int cnt);
    @(negedge clk);
    init = 1'b1; cfg_base = b; cfg_wide = w; cfg_count = (IW+1)'(cnt);
    @(negedge clk);
    init = 1'b0;
  endtask

  task automatic do_alloc(input int ag, input bit eok, input int eidx, input logic [AW-1:0] eaddr, input string tag);
    @(negedge clk);
    alloc_req[ag] = 1'b1;
    @(negedge clk);
    alloc_req[ag] = 1'b0;
    chk(alloc_vld[ag] == 1'b1, {tag, " strobe"}, 32'(alloc_vld[ag]), 1);
    chk(alloc_ok[ag] == eok, {tag, " ok"}, 32'(alloc_ok[ag]), 32'(eok));
    if (eok) begin
      chk(alloc_idx[ag] == IW'(eidx), {tag, " idx"}, 32'(alloc_idx[ag]), 32'(eidx));
      chk(alloc_addr[ag] == eaddr, {tag, " addr"}, alloc_addr[ag], eaddr);
    end
  endtask

  task automatic do_post(input int ag, input int idx);
    @(negedge clk);
    post_we[ag] = 1'b1; post_idx[ag] = IW'(idx);
    @(negedge clk);
    post_we[ag] = 1'b0;
  endtask

  task automatic do_read(input int ag, input bit eok, input int eidx, input logic [AW-1:0] eaddr, input string tag);
    @(negedge clk);
    mbx_rd[ag] = 1'b1;
    @(negedge clk);
    mbx_rd[ag] = 1'b0;
    chk(mbx_vld[ag] == 1'b1, {tag, " strobe"}, 32'(mbx_vld[ag]), 1);
    chk(mbx_ok[ag] == eok, {tag, " ok"}, 32'(mbx_ok[ag]), 32'(eok));
    if (eok) begin
      chk(mbx_idx[ag] == IW'(eidx), {tag, " idx"}, 32'(mbx_idx[ag]), 32'(eidx));
      chk(mbx_addr[ag] == eaddr, {tag, " addr"}, mbx_addr[ag], eaddr);
    end
  endtask

  // R1 R2 R3 R7: state straight after reset
  task automatic t_reset;
    chk(irq == 2'b00, "R1 irq low after reset", 32'(irq), 0);
    do_read(0, 1'b0, 0, '0, "R7 empty cpu mailbox after reset");
    do_alloc(0, 1'b1, 0, 32'h0, "R3 first slot after reset");
  endtask

  // R2 R3 R9: wide slots, then a same-cycle request from both agents
  task automatic t_both(input logic [AW-1:0] b);
    do_init(b, 1'b1, 128);
    do_alloc(0, 1'b1, 0, b, "R3 cpu slot 0");
    do_alloc(1, 1'b1, 1, b + 64, "R2 engine slot 1 wide");
    @(negedge clk);
    alloc_req = 2'b11;
    @(negedge clk);
    alloc_req = 2'b00;
    chk(alloc_vld == 2'b01, "R9 cpu answered alone first", 32'(alloc_vld), 1);
    chk(alloc_idx[0] == IW'(2), "R9 cpu slot", 32'(alloc_idx[0]), 2);
    @(negedge clk);
    chk(alloc_vld == 2'b10, "R9 engine answered next", 32'(alloc_vld), 2);
    chk(alloc_ok[1] && alloc_idx[1] == IW'(3), "R9 engine slot", 32'(alloc_idx[1]), 3);
    chk(alloc_addr[1] == b + 3*64, "R2 engine addr", alloc_addr[1], b + 3*64);
  endtask

  // R6 R7 R8: post to engine, FIFO order, interrupt level
  task automatic t_post(input logic [AW-1:0] b);
    do_post(0, 2);
    chk(irq == 2'b10, "R8 engine irq after post", 32'(irq), 2);
    do_post(0, 0);
    do_read(1, 1'b1, 2, b + 2*64, "R6 engine first mail");
    chk(irq[1] == 1'b1, "R8 irq held with mail left", 32'(irq[1]), 1);
    do_read(1, 1'b1, 0, b, "R6 engine second mail");
    chk(irq == 2'b00, "R8 irq low when empty", 32'(irq), 0);
    do_read(1, 1'b0, 0, '0, "R7 engine empty read");
    do_post(1, 3);
    chk(irq == 2'b01, "R8 cpu irq after engine post", 32'(irq), 1);
    do_read(0, 1'b1, 3, b + 3*64, "R6 cpu mail from engine");
  endtask

  // R4 R5 R10 R11: drain, fail, twin release, reissue
  task automatic t_drain(input logic [AW-1:0] b);
    do_init(b, 1'b0, 128);
    for (int k = 0; k < 128; k++)
      do_alloc(0, 1'b1, k, b + 32'(k) * 32, "R11 R3 drain");
    do_alloc(1, 1'b0, 0, '0, "R4 R11 empty pool");
    @(negedge clk);
    rel_we = 2'b11; rel_idx[0] = IW'(7); rel_idx[1] = IW'(3);
    @(negedge clk);
    rel_we = 2'b00;
    do_alloc(0, 1'b1, 7, b + 7*32, "R10 R5 cpu release first");
    do_alloc(1, 1'b1, 3, b + 3*32, "R10 R5 engine release second");
    do_alloc(0, 1'b0, 0, '0, "R4 empty again");
    @(negedge clk);
    rel_we[0] = 1'b1; rel_idx[0] = IW'(9);
    @(negedge clk);
    rel_we[0] = 1'b0;
    do_alloc(1, 1'b1, 9, b + 9*32, "R4 failed read changed nothing");
  endtask

  // R1: init discards pending mail
  task automatic t_init_clear(input logic [AW-1:0] b);
    do_post(1, 5);
    chk(irq[0] == 1'b1, "R8 cpu irq before init", 32'(irq[0]), 1);
    do_init(b, 1'b0, 128);
    chk(irq == 2'b00, "R1 irq cleared by init", 32'(irq), 0);
    do_read(0, 1'b0, 0, '0, "R1 mailbox emptied by init");
    do_alloc(0, 1'b1, 0, b, "R1 pool refilled by init");
  endtask

  initial begin
    rst_n = 1'b0; init = 1'b0; cfg_base = '0; cfg_wide = 1'b0; cfg_count = '0;
    alloc_req = '0; post_we = '0; post_idx = '0; rel_we = '0; rel_idx = '0; mbx_rd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_both(32'h0010_0000);
    t_post(32'h0010_0000);
    t_drain(32'h0002_0000);
    t_init_clear(32'h0004_0000);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule